// File: doc/BRIEF.md
# NAND Flash Window Access Sequencer

This block sits inside one chip-select window of a host memory bus that has been set aside for a NAND flash device. Each host request carries a window offset. Bits [13:12] of that offset decide what the request becomes on the NAND pins:

- a plain data transfer,
- a command-latch cycle,
- an address-latch cycle,
- a release that only drops the address-latch strobe and makes no bus cycle.

The data bus to the device is dedicated and never multiplexed with addresses.

Every real bus cycle has three phases: setup, strobe and hold. Their lengths come from the same three timing counts that the window would use for SRAM accesses. The address-latch strobe is sticky. It rises on an address write and stays high through any run of further address writes, so a multi-byte address goes out with no gap in the strobe.

The host side uses a valid/ready handshake. A request is taken on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` is low for the whole time a NAND cycle runs, which applies back-pressure to the host. A request that makes no bus cycle leaves `host_ready` high, so the next request can be taken on the following clock. Read data returns on a single-clock `rd_valid` pulse. The host cannot stall that pulse.

Top module: `nand_window_decoder`

## Requirements
- R1: Offset bits [13:12] select the access kind: 0 = data, 1 = command, 2 = address, 3 = strobe release. Offset bits [11:0] have no effect on the result.
- R2: During a command write, `nand_cle` is high on every clock that `nand_ce_n` is low. It rises on the same clock as chip-select falls, not at the strobe.
- R3: During an address write, `nand_ale` is high and `nand_cle` is low for the whole cycle.
- R4: Once raised, `nand_ale` stays high through further address writes and the idle clocks between them. A read leaves it unchanged.
- R5: A data or command write clears `nand_ale` from the first clock of its cycle. A release write also clears it.
- R6: A release write causes no chip-select, write-strobe or read-strobe activity. It is taken in one clock, and `host_ready` stays high.
- R7: During a data write, neither latch strobe is high, and `nand_dq_out` carries the write data with `nand_dq_oe` high. During a data read, `nand_dq_oe` stays low. The read value is `nand_dq_in` as sampled on the last strobe clock, and it is returned with `rd_valid`.
- R8: With timing counts S, W and H, a bus cycle holds chip-select low with both strobes high for S+1 clocks. The active strobe is then low for W+1 clocks. Chip-select then stays low for H+1 more clocks.
- R9: A read at a command, address or release offset makes no NAND cycle. On the next clock it pulses `rd_valid` with `rd_data` equal to zero.
- R10: After reset, chip-select and both strobes are high (inactive), both latch strobes are low, `nand_dq_oe` is low and `host_ready` is high.
- R11: A request is taken only when `host_valid` and `host_ready` are both high. `host_ready` is low for exactly S+W+H+3 clocks after a request that starts a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can take a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | OW | Offset of the request within the window |
| host_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-clock pulse: read data valid |
| rd_data | output | DW | Read data |
| cfg_setup | input | CW | Setup count S |
| cfg_strobe | input | CW | Strobe count W |
| cfg_hold | input | CW | Hold count H |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DW | Data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | DW | Data from the device |

## Verification
The bench sends runs of back-to-back address writes and checks `nand_ale` on every clock between them. A design that drops the strobe between address bytes, or lets a read clear it, fails there. Release writes are checked for any chip-select activity and for a ready stall. Command writes are checked for CLE rising on the same clock as chip-select; a design that raised it at the strobe would fail. Reads at the non-data offsets must return zero at once, while random upper offset bits and random setup, strobe and hold counts (including zero and the maximum) catch off-by-one phase lengths and a missed back-pressure window.

// File: rtl/nwd_pkg.sv
package nwd_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_REL  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic run;      // request starts a NAND bus cycle
    logic set_ale;  // address write
    logic clr_ale;  // any non-address write
    logic null_rd;  // read that makes no bus cycle
    logic is_cmd;   // command write
  } dec_s;
endpackage

// File: rtl/nwd_decode.sv
module nwd_decode
  import nwd_pkg::*;
#(
  parameter int OW = 14
) (
  input  logic          write,
  input  logic [OW-1:0] offset,
  output dec_s          dec
);
  localparam int SEL_HI = OW - 1;
  sel_e sel;

  assign sel = sel_e'(offset[SEL_HI -: 2]);

  always_comb begin
    dec.run     = (sel == SEL_DATA) || (write && ((sel == SEL_CMD) || (sel == SEL_ADDR)));
    dec.set_ale = write && (sel == SEL_ADDR);
    dec.clr_ale = write && (sel != SEL_ADDR);
    dec.null_rd = !write && (sel != SEL_DATA);
    dec.is_cmd  = write && (sel == SEL_CMD);
  end
endmodule

// File: rtl/nwd_timer.sv
module nwd_timer
  import nwd_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  output phase_e        phase,
  output logic          last
);
  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] strobe_q;
  logic [CW-1:0] hold_q;

  assign phase = phase_q;
  assign last  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q  <= PH_SETUP;
          cnt_q    <= cfg_setup;
          strobe_q <= cfg_strobe;
          hold_q   <= cfg_hold;
        end
        PH_SETUP: if (last) begin
          phase_q <= PH_STROBE;
          cnt_q   <= strobe_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last) begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) phase_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nwd_ale.sv
module nwd_ale (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic set_ale,
  input  logic clr_ale,
  output logic ale
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ale <= 1'b0;
    else if (take && set_ale)  ale <= 1'b1;
    else if (take && clr_ale)  ale <= 1'b0;
  end
endmodule

// File: rtl/nand_window_decoder.sv
module nand_window_decoder
  import nwd_pkg::*;
#(
  parameter int DW = 8,
  parameter int OW = 14,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [OW-1:0] host_offset,
  input  logic [DW-1:0] host_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [DW-1:0] nand_dq_in
);
  dec_s          dec;
  phase_e        phase;
  logic          last;
  logic          take;
  logic          wr_q;
  logic          cmd_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rd_hold;

  nwd_decode #(.OW(OW)) u_dec (
    .write  (host_write),
    .offset (host_offset),
    .dec    (dec)
  );

  nwd_timer #(.CW(CW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take && dec.run),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .cfg_hold   (cfg_hold),
    .phase      (phase),
    .last       (last)
  );

  nwd_ale u_ale (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .set_ale (dec.set_ale),
    .clr_ale (dec.clr_ale),
    .ale     (nand_ale)
  );

  assign host_ready  = (phase == PH_IDLE);
  assign take        = host_valid && host_ready;
  assign nand_ce_n   = (phase == PH_IDLE);
  assign nand_cle    = !nand_ce_n && cmd_q;
  assign nand_we_n   = !((phase == PH_STROBE) && wr_q);
  assign nand_re_n   = !((phase == PH_STROBE) && !wr_q);
  assign nand_dq_oe  = !nand_ce_n && wr_q;
  assign nand_dq_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      cmd_q    <= 1'b0;
      wdata_q  <= '0;
      rd_hold  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (take && dec.run) begin
        wr_q    <= host_write;
        cmd_q   <= dec.is_cmd;
        wdata_q <= host_wdata;
      end
      if (take && dec.null_rd) begin
        rd_valid <= 1'b1;
        rd_data  <= '0;
      end
      if ((phase == PH_STROBE) && last && !wr_q) rd_hold <= nand_dq_in;
      if ((phase == PH_HOLD) && last) begin
        cmd_q <= 1'b0;
        if (!wr_q) begin
          rd_valid <= 1'b1;
          rd_data  <= rd_hold;
        end
      end
    end
  end
endmodule

// File: rtl/nwd_checker.sv
module nwd_checker #(
  parameter int DW = 8,
  parameter int OW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_valid,
  input logic          host_ready,
  input logic          host_write,
  input logic [OW-1:0] host_offset,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          nand_ce_n,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_we_n,
  input logic          nand_re_n
);
  logic       acc;
  logic [1:0] sel;
  assign acc = host_valid && host_ready;
  assign sel = host_offset[OW-1 -: 2];

  a_r6_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_write && sel == 2'd3) |=> (nand_ce_n && host_ready));

  a_r4_ale_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_write && sel == 2'd2) |=> nand_ale);

  a_r5_ale_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_write && (sel == 2'd0 || sel == 2'd1)) |=> !nand_ale);

  a_r2_cle_with_select: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_write && sel == 2'd1) |=> (nand_cle && !nand_ce_n));

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r8_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_ce_n) |-> (nand_we_n && nand_re_n));

  a_r11_busy_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !host_ready);

  a_r9_null_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !host_write && sel != 2'd0) |=> (rd_valid && rd_data == '0));
endmodule

bind nand_window_decoder nwd_checker #(.DW(DW), .OW(OW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_valid  (host_valid),
  .host_ready  (host_ready),
  .host_write  (host_write),
  .host_offset (host_offset),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .nand_ce_n   (nand_ce_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n)
);

// File: tb/nand_window_decoder_tb.sv
module nand_window_decoder_tb;
  localparam int DW = 8;
  localparam int OW = 14;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_valid = 1'b0;
  logic          host_ready;
  logic          host_write = 1'b0;
  logic [OW-1:0] host_offset = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [DW-1:0] nand_dq_out;
  logic [DW-1:0] nand_dq_in = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_ale = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  nand_window_decoder #(.DW(DW), .OW(OW), .CW(CW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit f_run(input bit wr, input logic [1:0] sel);
    return (sel == 2'd0) || (wr && (sel == 2'd1 || sel == 2'd2));
  endfunction

  function automatic int f_busy(input bit run, input int s, input int w, input int h);
    return run ? s + w + h + 3 : 0;
  endfunction

  task automatic access(input bit wr, input logic [OW-1:0] ofs, input logic [DW-1:0] wd);
    logic [1:0] sel = ofs[OW-1 -: 2];
    bit run = f_run(wr, sel);
    int s = cfg_setup, w = cfg_strobe, h = cfg_hold;
    int busy = 0, n_su = 0, n_st = 0, n_hd = 0, n_cle = 0, ale_bad = 0, oe_bad = 0, dq_bad = 0;
    int n_rv = 0, lim = 0;
    bit seen_st = 0;
    logic [DW-1:0] got_rd = '0;
    logic [DW-1:0] din = DW'($urandom);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_offset = ofs; host_wdata = wd;
    nand_dq_in = din;
    if (wr && sel == 2'd2) exp_ale = 1'b1;
    else if (wr) exp_ale = 1'b0;
    @(posedge clk);
    forever begin
      @(negedge clk);
      host_valid = 1'b0;
      lim++;
      if (rd_valid) begin n_rv++; got_rd = rd_data; end
      if (nand_ale !== exp_ale) ale_bad++;
      if (host_ready || lim > 200) break;
      busy++;
      if (!nand_we_n || !nand_re_n) begin
        n_st++; seen_st = 1;
        if (wr && nand_dq_out !== wd) dq_bad++;
      end else if (!nand_ce_n) begin
        if (seen_st) n_hd++; else n_su++;
      end
      if (nand_cle) n_cle++;
      if (nand_dq_oe !== (wr && !nand_ce_n)) oe_bad++;
    end
    chk(busy == f_busy(run, s, w, h), "R11 ready low clocks", busy, f_busy(run, s, w, h));
    chk(n_su == (run ? s + 1 : 0), "R8 setup clocks", n_su, run ? s + 1 : 0);
    chk(n_st == (run ? w + 1 : 0), "R8 strobe clocks", n_st, run ? w + 1 : 0);
    chk(n_hd == (run ? h + 1 : 0), "R8 hold clocks", n_hd, run ? h + 1 : 0);
    chk(n_cle == ((wr && sel == 2'd1) ? busy : 0), "R2 cle clocks", n_cle,
        (wr && sel == 2'd1) ? busy : 0);
    chk(ale_bad == 0, "R4 R5 ale level", ale_bad, 0);
    chk(oe_bad == 0 && dq_bad == 0, "R7 data drive", oe_bad + dq_bad, 0);
    chk(n_rv == (wr ? 0 : 1), "R7 R9 rd_valid count", n_rv, wr ? 0 : 1);
    if (!wr) chk(got_rd == ((sel == 2'd0) ? din : '0), "R7 R9 read data", got_rd,
                 (sel == 2'd0) ? din : 0);
  endtask

  function automatic logic [OW-1:0] mk_ofs(input logic [1:0] sel);
    return {sel, 12'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R10 strobes idle", nand_ce_n, 1);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R10 latches low", nand_ale, 0);
    chk(host_ready, "R10 ready", host_ready, 1);
    rst_n = 1'b1;
    cfg_setup = 4'd1; cfg_strobe = 4'd2; cfg_hold = 4'd0;
    // R3 R4: sticky address run, read does not clear
    access(1'b1, mk_ofs(2'd2), 8'h11);
    chk(nand_ale && !nand_cle, "R3 ale after address", nand_ale, 1);
    access(1'b1, mk_ofs(2'd2), 8'h22);
    access(1'b0, mk_ofs(2'd0), 8'h00);
    chk(nand_ale, "R4 ale kept over read", nand_ale, 1);
    access(1'b1, mk_ofs(2'd2), 8'h33);
    // R6 release: no cycle, one clock
    access(1'b1, mk_ofs(2'd3), 8'hff);
    chk(!nand_ale, "R6 release clears ale", nand_ale, 0);
    // R5: command clears ale
    access(1'b1, mk_ofs(2'd2), 8'h44);
    access(1'b1, mk_ofs(2'd1), 8'h70);
    chk(!nand_ale, "R5 command clears ale", nand_ale, 0);
    // R9 null reads at non-data offsets, R1 low bits ignored
    access(1'b0, mk_ofs(2'd1), 8'h0);
    access(1'b0, mk_ofs(2'd2), 8'h0);
    access(1'b0, 14'h3fff, 8'h0);
    // R8 extremes
    cfg_setup = '0; cfg_strobe = '0; cfg_hold = '0;
    access(1'b1, 14'h0fff, 8'ha5);
    cfg_setup = '1; cfg_strobe = '1; cfg_hold = '1;
    access(1'b0, 14'h0000, 8'h0);
    // R1 random mix
    for (int i = 0; i < 300; i++) begin
      cfg_setup = CW'($urandom_range(0, 3));
      cfg_strobe = CW'($urandom_range(0, 3));
      cfg_hold = CW'($urandom_range(0, 3));
      access(1'($urandom), mk_ofs(2'($urandom)), DW'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule